// File: doc/BRIEF.md
# Multidrop Receive Mute Filter

This unit sits between a serial receiver and the host on a shared multidrop line. Its job is to stop words meant for other nodes from reaching the host. It keeps one mode bit: the unit is either active, where received words are forwarded, or muted, where words and receive events are dropped in hardware. While muted, the host sees neither a data strobe nor an interrupt.

A static select picks one of two ways to leave the muted state:

- **Idle-line wake:** a full idle frame on the line returns the unit to active.
- **Address wake:** a received word whose top bit is 1 is an address mark. Its low four bits are compared with a four-bit node address. A match returns the unit to active, and that mark is forwarded.

In address mode, an address mark that names another node while the unit is active sends the unit back to mute. A mute-request strobe from the host forces the muted state at once.

Every output is registered. A decision taken on the inputs at clock edge N is visible after edge N.

Top module: `mute_wake_filter`

## Requirements
- R1: After reset the unit is active (`muted_o`=0), and `word_valid_o` and `event_irq_o` are 0.
- R2: A `mute_req_i` pulse sets `muted_o` to 1 after that clock edge, whatever the mode and the other inputs.
- R3: While muted, no word is forwarded and no interrupt is raised, except the one address-mark word that wakes the unit in address mode (R4).
- R4: In address mode (`wake_sel_i`=1), while muted, a valid word with bit DATA_W-1 = 1 and bits 3:0 equal to `node_addr_i` clears `muted_o`. The same word appears on `word_o`, with `word_valid_o` and `event_irq_o` high, one cycle later.
- R5: In address mode, while muted, these inputs leave the unit muted and forward nothing:
  - plain words (top bit 0);
  - non-matching address marks;
  - `idle_det_i`.
- R6: In address mode, while active, a valid address mark whose low four bits differ from `node_addr_i` sets `muted_o` and is not forwarded.
- R7: In address mode, while active, plain words and matching address marks are forwarded unchanged, with `word_valid_o` and `event_irq_o` pulsing for one cycle.
- R8: In idle-line mode (`wake_sel_i`=0), while muted, `idle_det_i` clears `muted_o` without raising an interrupt. A word arriving in that same cycle is dropped. The next valid word is forwarded.
- R9: In idle-line mode, address marks have no special meaning:
  - while active, every valid word is forwarded;
  - while muted, every word is dropped.
- R10: While active, `idle_det_i` raises `event_irq_o` for one cycle without `word_valid_o`.
- R11: A mute request overrides any word, address match or idle detect in the same cycle. That word is dropped and no interrupt follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_word_i | input | DATA_W | Received word from the serial receiver |
| rx_valid_i | input | 1 | One-cycle strobe, `rx_word_i` is new |
| idle_det_i | input | 1 | One-cycle strobe, a full idle frame was seen |
| wake_sel_i | input | 1 | Wake method: 0 idle line, 1 address mark |
| node_addr_i | input | 4 | This node's address |
| mute_req_i | input | 1 | One-cycle strobe forcing mute mode |
| word_o | output | DATA_W | Forwarded word, held between strobes |
| word_valid_o | output | 1 | Gated data-valid strobe |
| event_irq_o | output | 1 | Gated interrupt request |
| muted_o | output | 1 | Current mode, 1 = muted |

## Verification
The assertions take for granted that `rx_valid_i`, `idle_det_i` and `mute_req_i` are single-cycle strobes. They also assume that `wake_sel_i` and `node_addr_i` are held steady around any cycle in which a strobe is present, because the wake and re-mute properties compare a strobe with the settings of the same cycle. The bench changes the wake method and the node address only at negative edges between steps, with every strobe low. It drives at most one word per step, so each step's effect is observed before the next input arrives.

// File: rtl/mwf_pkg.sv
package mwf_pkg;
  typedef enum logic {
    WAKE_IDLE = 1'b0,
    WAKE_MARK = 1'b1
  } wake_e;

  // per-cycle decision handed from the mode controller to the output stage
  typedef struct packed {
    logic pass;     // forward the current word
    logic irq;      // raise an interrupt
    logic mute_nx;  // mode for the next cycle
  } step_t;
endpackage

// File: rtl/mwf_classify.sv
module mwf_classify #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [ADDR_W-1:0] node_addr_i,
  output logic              is_mark_o,
  output logic              addr_hit_o
);
  localparam int MARK_BIT = DATA_W - 1;

  function automatic logic mark_of(input logic [DATA_W-1:0] w);
    return w[MARK_BIT];
  endfunction

  function automatic logic hit_of(input logic [DATA_W-1:0] w,
                                  input logic [ADDR_W-1:0] a);
    return (w[ADDR_W-1:0] == a);
  endfunction

  assign is_mark_o  = mark_of(word_i);
  assign addr_hit_o = hit_of(word_i, node_addr_i);
endmodule

// File: rtl/mwf_mode_ctrl.sv
module mwf_mode_ctrl
  import mwf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rx_valid_i,
  input  logic  idle_det_i,
  input  wake_e wake_i,
  input  logic  mute_req_i,
  input  logic  is_mark_i,
  input  logic  addr_hit_i,
  output logic  mute_q_o,
  output step_t step_o
);
  logic mute_q;
  logic mark_wake, mark_miss;

  assign mark_wake = (wake_i == WAKE_MARK) && rx_valid_i && is_mark_i && addr_hit_i;
  assign mark_miss = (wake_i == WAKE_MARK) && rx_valid_i && is_mark_i && !addr_hit_i;

  always_comb begin
    step_o = '{pass: 1'b0, irq: 1'b0, mute_nx: mute_q};
    if (mute_req_i) begin
      step_o.mute_nx = 1'b1;
    end else if (mute_q) begin
      if (mark_wake) begin
        step_o.mute_nx = 1'b0;
        step_o.pass    = 1'b1;
        step_o.irq     = 1'b1;
      end else if ((wake_i == WAKE_IDLE) && idle_det_i) begin
        step_o.mute_nx = 1'b0;
      end
    end else begin
      if (mark_miss) begin
        step_o.mute_nx = 1'b1;
      end else begin
        if (rx_valid_i) begin
          step_o.pass = 1'b1;
          step_o.irq  = 1'b1;
        end
        if (idle_det_i) step_o.irq = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mute_q <= 1'b0;
    else        mute_q <= step_o.mute_nx;
  end

  assign mute_q_o = mute_q;

  p_req_mutes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mute_req_i |=> mute_q);
  p_idle_wakes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_q && wake_i == WAKE_IDLE && idle_det_i && !mute_req_i) |=> !mute_q);
endmodule

// File: rtl/mwf_out_stage.sv
module mwf_out_stage
  import mwf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_t             step_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] word_o,
  output logic              valid_o,
  output logic              irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o  <= '0;
      valid_o <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      valid_o <= step_i.pass;
      irq_o   <= step_i.irq;
      if (step_i.pass) word_o <= word_i;
    end
  end

  p_valid_has_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> irq_o);
endmodule

// File: rtl/mute_wake_filter.sv
module mute_wake_filter
  import mwf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_word_i,
  input  logic              rx_valid_i,
  input  logic              idle_det_i,
  input  logic              wake_sel_i,
  input  logic [3:0]        node_addr_i,
  input  logic              mute_req_i,
  output logic [DATA_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              event_irq_o,
  output logic              muted_o
);
  localparam int ADDR_W = 4;

  wake_e wake;
  logic  is_mark, addr_hit, mute_q;
  step_t step;

  assign wake = wake_e'(wake_sel_i);

  mwf_classify #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_classify (
    .word_i(rx_word_i), .node_addr_i(node_addr_i),
    .is_mark_o(is_mark), .addr_hit_o(addr_hit));

  mwf_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid_i), .idle_det_i(idle_det_i),
    .wake_i(wake), .mute_req_i(mute_req_i), .is_mark_i(is_mark),
    .addr_hit_i(addr_hit), .mute_q_o(mute_q), .step_o(step));

  mwf_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .step_i(step), .word_i(rx_word_i),
    .word_o(word_o), .valid_o(word_valid_o), .irq_o(event_irq_o));

  assign muted_o = mute_q;

  p_silent_when_muted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_q && !(wake == WAKE_MARK && rx_valid_i && is_mark && addr_hit))
      |=> (!word_valid_o && !event_irq_o));
  p_match_wakes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_q && wake == WAKE_MARK && rx_valid_i && is_mark && addr_hit && !mute_req_i)
      |=> (!muted_o && word_valid_o && word_o == $past(rx_word_i)));
  p_miss_mutes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mute_q && wake == WAKE_MARK && rx_valid_i && is_mark && !addr_hit)
      |=> (muted_o && !word_valid_o));
  p_req_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mute_req_i |=> (!word_valid_o && !event_irq_o));
endmodule

// File: tb/mute_wake_filter_tb.sv
module mute_wake_filter_tb;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] rx_word = '0;
  logic          rx_valid = 1'b0, idle_det = 1'b0, wake_sel = 1'b0, mute_req = 1'b0;
  logic [3:0]    node_addr = 4'd0;
  logic [DW-1:0] word_o;
  logic          word_valid_o, event_irq_o, muted_o;

  int checks = 0;
  int fails  = 0;
  bit m_mute = 1'b0;
  logic [DW-1:0] m_word = '0;

  always #2 clk = ~clk;

  mute_wake_filter #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_word_i(rx_word), .rx_valid_i(rx_valid),
    .idle_det_i(idle_det), .wake_sel_i(wake_sel), .node_addr_i(node_addr),
    .mute_req_i(mute_req), .word_o(word_o), .word_valid_o(word_valid_o),
    .event_irq_o(event_irq_o), .muted_o(muted_o));

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one input cycle, then compare against the requirement model
  task automatic step(input logic [DW-1:0] w, input bit v, input bit idl,
                      input bit req, input string tag);
    bit mark, hit, e_valid, e_irq, e_mute;
    mark = w[DW-1];
    hit  = (w[3:0] == node_addr);
    e_valid = 0; e_irq = 0; e_mute = m_mute;
    if (req) e_mute = 1;
    else if (m_mute) begin
      if (wake_sel && v && mark && hit) begin e_mute = 0; e_valid = 1; e_irq = 1; end
      else if (!wake_sel && idl) e_mute = 0;
    end else if (wake_sel && v && mark && !hit) e_mute = 1;
    else begin
      if (v) begin e_valid = 1; e_irq = 1; end
      if (idl) e_irq = 1;
    end
    if (e_valid) m_word = w;
    m_mute = e_mute;
    rx_word = w; rx_valid = v; idle_det = idl; mute_req = req;
    @(negedge clk);
    rx_valid = 0; idle_det = 0; mute_req = 0;
    checks++;
    if (word_valid_o !== e_valid || event_irq_o !== e_irq || muted_o !== e_mute ||
        (e_valid && word_o !== m_word)) begin
      fails++;
      $display("FAIL %s: word=%h v=%b i=%b q=%b got valid=%b irq=%b mute=%b data=%h exp valid=%b irq=%b mute=%b data=%h",
               tag, w, v, idl, req, word_valid_o, event_irq_o, muted_o, word_o,
               e_valid, e_irq, e_mute, m_word);
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (muted_o !== 0 || word_valid_o !== 0 || event_irq_o !== 0) begin
      fails++;
      $display("FAIL R1: got mute=%b valid=%b irq=%b exp 0 0 0", muted_o, word_valid_o, event_irq_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R9 / R10: idle-line mode active, every word forwarded, idle gives irq
    wake_sel = 0;
    for (int w = 0; w < 256; w++) step(DW'(w), 1, 0, 0, "R9_active_pass");
    step('0, 0, 1, 0, "R10_idle_irq");
    // R11 / R2: request beats a same-cycle word
    step(8'h55, 1, 0, 1, "R11_req_drops_word");
    // R3 / R9: muted drops every word
    for (int w = 0; w < 256; w++) step(DW'(w), 1, 0, 0, "R3_R9_muted_drop");
    // R8: idle wake, same-cycle word dropped, next word passes
    step(8'h3C, 1, 1, 0, "R8_idle_wake");
    step(8'h3D, 1, 0, 0, "R8_next_word");
    // R11: request beats idle detect
    step('0, 0, 1, 1, "R11_req_over_idle");
    step('0, 0, 0, 0, "R2_stays_muted");

    // R4 / R5: address mode, muted, all node addresses x all words
    wake_sel = 1;
    for (int a = 0; a < 16; a++) begin
      node_addr = 4'(a);
      for (int w = 0; w < 256; w++) begin
        step('0, 0, 0, 1, "R2_mute_req");
        step('0, 0, 1, 0, "R5_idle_ignored");
        step(DW'(w), 1, 0, 0, "R4_R5_mark_sweep");
      end
    end

    // R6 / R7: address mode active
    node_addr = 4'hA;
    step('0, 0, 0, 1, "R2_mute_req");
    step(8'h8A, 1, 0, 0, "R4_wake_match");
    step(8'h17, 1, 0, 0, "R7_plain_pass");
    step(8'h8A, 1, 0, 0, "R7_match_pass");
    step('0, 0, 1, 0, "R10_idle_irq_mark");
    step(8'h8B, 1, 0, 0, "R6_miss_mutes");
    step(8'h17, 1, 0, 0, "R5_plain_dropped");
    step(8'h8A, 1, 0, 1, "R11_req_over_match");
    step(8'h8A, 1, 0, 0, "R4_wake_again");
    for (int a = 0; a < 16; a++) begin
      step(DW'(8'h80 | a), 1, 0, 0, "R6_R7_active_sweep");
      if (m_mute) step(8'h8A, 1, 0, 0, "R4_rewake");
    end
    finish_run();
  end
endmodule